// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block holds the per-pin interrupt logic of a small general-purpose I/O port (eight pins by default). It receives the pin levels, already synchronized to its clock, and the per-pin direction bits from the surrounding port. It turns pin activity into latched status bits. Software configures it through a simple register bus. For each pin, software picks level or edge detection, one edge or both edges, and the active polarity. Software then reads the raw status and the masked status, and acknowledges events by writing ones to a clear register.

Each pin has a sticky raw status bit. An edge-mode pin sets its bit on a qualifying transition, but only while the pin is an input. A level-mode pin sets its bit again on every cycle in which the pin sits at the active level, so an acknowledge has no lasting effect while that level persists. The mask register selects which raw bits reach the single combined interrupt line.

Register words are selected by a 3-bit word address. Writes take effect at the clock edge. Reads are combinational and need no strobe.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset the sense, both-edge, polarity, mask and raw status registers are all zero, every register address reads 0, and `irq_o` is low.
- R2: Addresses 0 (sense), 1 (both-edge), 2 (polarity) and 3 (mask) are read/write and store only the low NPINS bits of the written word. Their read value is zero-extended. Unused address 7 and the clear address 6 read 0.
- R3: With sense bit 0 and both-edge bit 0, an input pin (direction bit 0) sets its raw bit on a rising transition when its polarity bit is 1, and on a falling transition when its polarity bit is 0. The bit is visible one clock edge after the cycle in which the new pin level is presented.
- R4: With sense bit 0 and both-edge bit 1, an input pin sets its raw bit on any transition, whatever its polarity bit.
- R5: A pin whose direction bit is 1 (output) never sets its raw bit through edge detection.
- R6: With sense bit 1, the raw bit is set on every clock edge at which the pin equals its polarity bit (1 = high active, 0 = low active), whatever the direction bit.
- R7: Writing address 6 clears each raw bit whose written bit is 1 and leaves the others unchanged.
- R8: When a clear and a new set condition (edge or active level) hit the same bit at the same clock edge, the bit ends set.
- R9: Address 4 reads the raw status and address 5 reads raw AND mask. `irq_o` is high exactly when raw AND mask is non-zero.
- R10: A raw bit that is set stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Synchronized pin levels |
| dir_i | input | NPINS | Pin direction, 1 = output, 0 = input |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt, high when any masked status bit is set |

## Verification
Two functions can act on the same raw bit at the same clock edge: a software acknowledge, and a new set condition from an edge or an active level. The bench provokes an edge collision by changing the pin pattern on the very cycle in which the clear write is presented. It provokes a level collision by clearing all bits while level-mode pins sit at their active level. The bit is judged correct when it reads back as set afterwards, while bits without a set condition read back as cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_SENSE  = 3'd0,
    RA_BOTH   = 3'd1,
    RA_POL    = 3'd2,
    RA_MASK   = 3'd3,
    RA_RAW    = 3'd4,
    RA_MSTAT  = 3'd5,
    RA_CLEAR  = 3'd6,
    RA_UNUSED = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [NPINS-1:0]      sense_o,
  output logic [NPINS-1:0]      both_o,
  output logic [NPINS-1:0]      pol_o,
  output logic [NPINS-1:0]      mask_o,
  output logic [NPINS-1:0]      clr_o
);
  logic [NPINS-1:0] wbits;
  assign wbits = wdata_i[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_o <= '0;
      both_o  <= '0;
      pol_o   <= '0;
      mask_o  <= '0;
    end else if (wr_i) begin
      case (reg_addr_e'(addr_i))
        RA_SENSE: sense_o <= wbits;
        RA_BOTH:  both_o  <= wbits;
        RA_POL:   pol_o   <= wbits;
        RA_MASK:  mask_o  <= wbits;
        default:  ;
      endcase
    end
  end

  assign clr_o = (wr_i && reg_addr_e'(addr_i) == RA_CLEAR) ? wbits : '0;

  // R2: a write to the sense word lands there on the next edge
  a_r2_sense_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && reg_addr_e'(addr_i) == RA_SENSE) |=> sense_o == $past(wbits));
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic is_out_i,
  input  logic sense_i,
  input  logic both_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic raw_o
);
  logic prev_q;
  logic raw_q;
  logic at_level;
  logic edge_hit;
  logic set_hit;

  assign at_level = (pin_i == pol_i);
  assign edge_hit = !is_out_i && (pin_i != prev_q) && (both_i || at_level);
  assign set_hit  = sense_i ? at_level : edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= pin_i;
      raw_q  <= set_hit | (raw_q & ~clr_i);
    end
  end

  assign raw_o = raw_q;

  a_r6_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_i && at_level) |=> raw_q);
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && clr_i) |=> raw_q);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_hit) |=> !raw_q);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr_i) |=> raw_q);
  a_r5_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (is_out_i && !sense_i && !raw_q) |=> !raw_q);
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]      sense_i,
  input  logic [NPINS-1:0]      both_i,
  input  logic [NPINS-1:0]      pol_i,
  input  logic [NPINS-1:0]      mask_i,
  input  logic [NPINS-1:0]      raw_i,
  output logic [DATA_W-1:0]     rdata_o
);
  logic [NPINS-1:0] sel;

  always_comb begin
    case (reg_addr_e'(addr_i))
      RA_SENSE: sel = sense_i;
      RA_BOTH:  sel = both_i;
      RA_POL:   sel = pol_i;
      RA_MASK:  sel = mask_i;
      RA_RAW:   sel = raw_i;
      RA_MSTAT: sel = raw_i & mask_i;
      default:  sel = '0;
    endcase
  end

  assign rdata_o = DATA_W'(sel);
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS-1:0]      pin_i,
  input  logic [NPINS-1:0]      dir_i,
  input  logic                  reg_wr_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  logic [NPINS-1:0] sense_q, both_q, pol_q, mask_q, clr_w, raw_w;

  gpio_irq_cfg #(.NPINS(NPINS), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .sense_o(sense_q), .both_o(both_q),
    .pol_o(pol_q), .mask_o(mask_q), .clr_o(clr_w)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_irq_pin u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i[g]), .is_out_i(dir_i[g]),
      .sense_i(sense_q[g]), .both_i(both_q[g]), .pol_i(pol_q[g]),
      .clr_i(clr_w[g]), .raw_o(raw_w[g])
    );
  end

  gpio_irq_rdmux #(.NPINS(NPINS), .DATA_W(DATA_W)) u_rd (
    .addr_i(reg_addr_i), .sense_i(sense_q), .both_i(both_q),
    .pol_i(pol_q), .mask_i(mask_q), .raw_i(raw_w), .rdata_o(reg_rdata_o)
  );

  assign irq_o = |(raw_w & mask_q);

  // R9: the line can only be high while some pin is enabled
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (mask_q != '0));
  // R1: nothing pending on the first edge after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;
  localparam int N = 8;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin = '0;
  logic [N-1:0] dir = '0;
  logic         wr = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .DATA_W(W)) u_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .dir_i(dir), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // configuration used by the sweep: pin i takes sense=i[2], both=i[1], pol=i[0]
  localparam logic [N-1:0] SW_SENSE = 8'hF0;
  localparam logic [N-1:0] SW_BOTH  = 8'hCC;
  localparam logic [N-1:0] SW_POL   = 8'hAA;

  function automatic logic [N-1:0] lvl(input logic [N-1:0] x);
    return SW_SENSE & ~(x ^ SW_POL);
  endfunction

  function automatic logic [N-1:0] edg(input logic [N-1:0] a, input logic [N-1:0] b,
                                      input logic [N-1:0] d);
    return ~SW_SENSE & ~d & (a ^ b) & (SW_BOTH | ~(b ^ SW_POL));
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset read", v, '0);
    end
    chk("R1 irq after reset", {31'b0, irq}, '0);

    // R2: config readback, upper bits dropped
    wr_reg(3'd0, 32'hFFFF_FF5A);
    wr_reg(3'd1, 32'h1234_563C);
    wr_reg(3'd2, 32'h8000_00A5);
    wr_reg(3'd3, 32'hFFFF_0081);
    rd(3'd0, v); chk("R2 sense", v, 32'h5A);
    rd(3'd1, v); chk("R2 both", v, 32'h3C);
    rd(3'd2, v); chk("R2 pol", v, 32'hA5);
    rd(3'd3, v); chk("R2 mask", v, 32'h81);
    rd(3'd6, v); chk("R2 clear reads 0", v, '0);
    rd(3'd7, v); chk("R2 unused reads 0", v, '0);

    // R8: clear and rising edge at the same edge
    wr_reg(3'd0, 0); wr_reg(3'd1, 0); wr_reg(3'd2, 32'hFF); wr_reg(3'd3, 32'hFF);
    dir = '0; pin = '0;
    wr_reg(3'd6, 32'hFF);
    @(negedge clk);
    wr = 1'b1; addr = 3'd6; wdata = 32'hFF; pin = 8'h0F;
    @(negedge clk);
    wr = 1'b0;
    rd(3'd4, v); chk("R8 edge beats clear", v, 32'h0F);
    chk("R9 irq with pending", {31'b0, irq}, 1);

    // R7: partial clear, R10: holds afterwards
    wr_reg(3'd6, 32'h05);
    rd(3'd4, v); chk("R7 partial clear", v, 32'h0A);
    repeat (3) @(negedge clk);
    rd(3'd4, v); chk("R10 sticky", v, 32'h0A);
    wr_reg(3'd3, 32'h05);
    rd(3'd5, v); chk("R9 masked zero", v, 0);
    chk("R9 irq low when masked off", {31'b0, irq}, 0);

    // sweep: R3/R4/R5/R6/R8/R9/R10 over pin patterns and directions
    wr_reg(3'd0, 32'(SW_SENSE));
    wr_reg(3'd1, 32'(SW_BOTH));
    wr_reg(3'd2, 32'(SW_POL));
    for (int ai = 0; ai < 16; ai++) begin
      for (int bi = 0; bi < 16; bi++) begin
        logic [N-1:0] a, b, d, m, e;
        a = 8'(ai * 53) ^ 8'h0F;
        b = 8'(bi * 83) ^ 8'hA6;
        d = 8'((ai + bi) * 39);
        m = 8'(ai * 16 + bi) ^ 8'h3C;
        @(negedge clk);
        pin = a; dir = d;
        wr_reg(3'd3, 32'(m));
        // clear everything while level pins are active: they survive (R8)
        @(negedge clk);
        wr = 1'b1; addr = 3'd6; wdata = 32'hFF;
        @(negedge clk);
        wr = 1'b0;
        rd(3'd4, v); chk("R6/R8 level survives clear", v, 32'(lvl(a)));
        pin = b;
        @(negedge clk);
        e = lvl(a) | lvl(b) | edg(a, b, d);
        rd(3'd4, v); chk("R3/R4/R5/R6 raw after transition", v, 32'(e));
        rd(3'd5, v); chk("R9 masked status", v, 32'(e & m));
        chk("R9 irq line", {31'b0, irq}, {31'b0, |(e & m)});
        @(negedge clk);
        rd(3'd4, v); chk("R10 raw holds", v, 32'(e));
      end
    end

    summary();
  end
endmodule